// File: doc/BRIEF.md
# Cycle Counter Compare Timer

This block is the timer of a small processor's system-control unit. A free-running cycle counter advances on every clock edge, not once per retired instruction. A match register holds a target value. When the counter takes on a value equal to the match value, the block raises a timer interrupt request. The request stays raised until software writes the match register again. Software can stop and restart the counter through a halt bit in a 32-bit control register. The same control register shows the pending timer request in its top hardware-interrupt position.

All three registers are reached through one write port and one read port. Each port selects a register by a 5-bit register number. Reads are combinational and see the registered state of the current cycle. A write takes effect at the next rising clock edge.

Top module: `cyc_cmp_timer`

## Requirements
- R1: After reset the counter reads 0, the match register reads 0, the control register (register 13) reads 0x0880007C, and `timer_irq` is 0. This means counting starts halted.
- R2: While control bit 27 (halt) is 0, the counter (register 9) grows by one at every clock edge. It wraps from all ones to 0 and keeps running.
- R3: While control bit 27 is 1, the counter holds its value. A write to the control register changes the halt state from the edge at which it is stored, so the counting at that same edge still follows the old value.
- R4: A write to register 9 loads the counter with the low bits of the write data. The load wins over the increment at the same edge, and counting resumes from the loaded value.
- R5: `timer_irq` rises at the same edge at which the counter takes on (by increment or by load) a value equal to the match register (register 11).
- R6: Once raised, `timer_irq` stays at 1 while the counter moves past the match value. It only falls at the edge that stores a write to register 11, whatever value is written. That write also wins over a match at the same edge.
- R7: Bit 15 of the control register always reads as the current `timer_irq`. The bit 15 of the write data is ignored, and all other control bits read back as written.
- R8: `rd_data` follows `rd_sel` in the same cycle with no added latency. The counter and match values are zero-extended to 32 bits, and any other register number reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 5 | Register number to read |
| rd_data | output | 32 | Read data of the selected register |
| timer_irq | output | 1 | Pending timer interrupt request |

## Verification
The bench builds the block with an 8-bit counter (`CNT_W = 8`). With that width, a wrap from 0xFF to 0 comes within a few hundred cycles, and random match values are hit often. This exercises the raise, hold-past and clear paths many times, along with their interplay with loads and halts. Directed steps pin down the exact edge of the first match, a load at the same edge as a running increment, and a match register write against a pending request.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 5;
  localparam logic [SEL_W-1:0] SEL_CNT = 5'd9;
  localparam logic [SEL_W-1:0] SEL_CMP = 5'd11;
  localparam logic [SEL_W-1:0] SEL_CTL = 5'd13;
  localparam int HALT_BIT = 27;
  localparam int PEND_BIT = 15;
  localparam logic [REG_W-1:0] CTL_RST = 32'h0880_007C;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             cnt_chg
);
  always_comb begin
    cnt_chg = load | run;
    if (load)     cnt_nxt = load_val;
    else if (run) cnt_nxt = cnt_q + 1'b1;
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_chg) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_chg,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq_q
);
  logic irq_d;
  logic hit;

  always_comb begin
    hit = cnt_chg && (cnt_nxt == cmp_q);
    if (cmp_wr) irq_d = 1'b0;
    else        irq_d = irq_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_wr) cmp_q <= cmp_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_val,
  output logic [REG_W-1:0] ctl_q,
  output logic             halt
);
  logic [REG_W-1:0] ctl_d;

  always_comb begin
    ctl_d = ctl_val;
    ctl_d[PEND_BIT] = 1'b0;
    halt = ctl_q[HALT_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_wr) ctl_q <= ctl_d;
  end
endmodule

// File: rtl/cyc_cmp_timer.sv
module cyc_cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             timer_irq
);
  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic             cnt_wr, cmp_wr, ctl_wr;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, cmp_q;
  logic             cnt_chg;
  logic [REG_W-1:0] ctl_q;
  logic             halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  always_comb begin
    cnt_wr = wr_en && (wr_sel == SEL_CNT);
    cmp_wr = wr_en && (wr_sel == SEL_CMP);
    ctl_wr = wr_en && (wr_sel == SEL_CTL);
  end

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .load(cnt_wr), .load_val(wr_data[CNT_W-1:0]),
    .run(!halt), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .cnt_chg(cnt_chg)
  );

  tmr_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_s_n), .cnt_chg(cnt_chg), .cnt_nxt(cnt_nxt),
    .cmp_wr(cmp_wr), .cmp_val(wr_data[CNT_W-1:0]), .cmp_q(cmp_q), .irq_q(timer_irq)
  );

  tmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .ctl_wr(ctl_wr), .ctl_val(wr_data),
    .ctl_q(ctl_q), .halt(halt)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      SEL_CNT: rd_data[CNT_W-1:0] = cnt_q;
      SEL_CMP: rd_data[CNT_W-1:0] = cmp_q;
      SEL_CTL: begin
        rd_data = ctl_q;
        rd_data[PEND_BIT] = timer_irq;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cmp_q,
  input logic [REG_W-1:0] ctl_q,
  input logic             timer_irq
);
  logic cnt_w, cmp_w;
  assign cnt_w = wr_en && (wr_sel == SEL_CNT);
  assign cmp_w = wr_en && (wr_sel == SEL_CMP);

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!ctl_q[HALT_BIT] && !cnt_w) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_hold_halted_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctl_q[HALT_BIT] && !cnt_w) |=> $stable(cnt_q));

  p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    cnt_w |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

  p_rise_on_match_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(timer_irq) |-> (cnt_q == cmp_q));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (timer_irq && !cmp_w) |=> timer_irq);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmp_w |=> !timer_irq);

  p_pend_not_stored_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ctl_q[PEND_BIT]);
endmodule

bind cyc_cmp_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt_q(cnt_q), .cmp_q(cmp_q), .ctl_q(ctl_q), .timer_irq(timer_irq)
);

// File: tb/tb_cyc_cmp_timer.sv
module tb_cyc_cmp_timer;
  localparam int CNT_W = 8;
  localparam logic [31:0] MASK = 32'hFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        timer_irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_cnt, m_cmp, m_ctl;
  logic        m_irq;

  cyc_cmp_timer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .timer_irq(timer_irq)
  );

  always #10 clk = ~clk;

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [31:0] exp_rd(input logic [4:0] s);
    logic [31:0] v;
    case (s)
      5'd9:    v = m_cnt;
      5'd11:   v = m_cmp;
      5'd13: begin v = m_ctl; v[15] = m_irq; end
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  task automatic model_edge(input logic we, input logic [4:0] ws, input logic [31:0] wd);
    logic [31:0] nc;
    logic chg;
    chg = 1'b0;
    nc = m_cnt;
    if (we && ws == 5'd9) begin nc = wd & MASK; chg = 1'b1; end
    else if (!m_ctl[27]) begin nc = (m_cnt + 1) & MASK; chg = 1'b1; end
    if (we && ws == 5'd11) m_irq = 1'b0;
    else if (chg && nc == m_cmp) m_irq = 1'b1;
    if (we && ws == 5'd11) m_cmp = wd & MASK;
    if (we && ws == 5'd13) begin m_ctl = wd; m_ctl[15] = 1'b0; end
    m_cnt = nc;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, sample 5 ns after the edge
  task automatic step(input string tag, input logic we, input logic [4:0] ws,
                      input logic [31:0] wd, input logic [4:0] rs);
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
    @(posedge clk);
    model_edge(we, ws, wd);
    #5;
    check(tag, rd_data, exp_rd(rs));
    check(tag, {31'b0, timer_irq}, {31'b0, m_irq});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_cnt = 0; m_cmp = 0; m_ctl = 32'h0880_007C; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_sel = 5'd9;  #1 check("R1", rd_data, 32'h0);
    rd_sel = 5'd11; #1 check("R1", rd_data, 32'h0);
    rd_sel = 5'd13; #1 check("R1", rd_data, 32'h0880_007C);
    check("R1", {31'b0, timer_irq}, 32'h0);
    // R8 unmapped register and same-cycle read
    rd_sel = 5'd3; #1 check("R8", rd_data, 32'h0);
    @(negedge clk);
    step("R3", 1'b0, 5'd0, 32'h0, 5'd9);
    // R3 halt change at the storing edge still follows old halt
    step("R3", 1'b1, 5'd13, 32'h0080_007C, 5'd9);
    check("R3", rd_data, 32'h0);
    // R5 match at 5 set before count reaches it
    step("R5", 1'b1, 5'd11, 32'h5, 5'd9);
    for (int i = 0; i < 6; i++) step("R5", 1'b0, 5'd0, 32'h0, 5'd9);
    // R6 hold past match
    for (int i = 0; i < 4; i++) step("R6", 1'b0, 5'd0, 32'h0, 5'd13);
    check("R6", {31'b0, timer_irq}, 32'h1);
    // R4 load wins over increment; R2 wrap
    step("R4", 1'b1, 5'd9, 32'hFFFF_FFFE, 5'd9);
    check("R4", rd_data, 32'hFE);
    step("R2", 1'b0, 5'd0, 32'h0, 5'd9);
    step("R2", 1'b0, 5'd0, 32'h0, 5'd9);
    check("R2", rd_data, 32'h0);
    // R7 pending bit in write data ignored, halt set
    step("R7", 1'b1, 5'd13, 32'h0800_8000, 5'd13);
    check("R7", rd_data, 32'h0800_8000);
    step("R3", 1'b0, 5'd0, 32'h0, 5'd9);
    step("R3", 1'b0, 5'd0, 32'h0, 5'd9);
    // R6 clear by compare write even with value equal to count
    step("R6", 1'b1, 5'd11, m_cnt, 5'd13);
    check("R6", {31'b0, timer_irq}, 32'h0);
    // R6 compare write wins over a same-edge match
    step("R6", 1'b1, 5'd13, 32'h0, 5'd9);
    step("R6", 1'b1, 5'd11, (m_cnt + 1) & MASK, 5'd9);
    step("R6", 1'b1, 5'd11, (m_cnt + 2) & MASK, 5'd13);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [4:0] ws, rs;
      logic [31:0] wd;
      int k;
      we = ($urandom_range(0, 3) == 0);
      k = $urandom_range(0, 9);
      ws = (k < 3) ? 5'd9 : (k < 6) ? 5'd11 : (k < 9) ? 5'd13 : 5'($urandom);
      wd = $urandom;
      if (ws == 5'd13 && $urandom_range(0, 3) != 0) wd[27] = 1'b0;
      if (ws == 5'd11) wd = (m_cnt + $urandom_range(0, 12)) & MASK;
      k = $urandom_range(0, 3);
      rs = (k == 0) ? 5'd9 : (k == 1) ? 5'd11 : (k == 2) ? 5'd13 : 5'($urandom);
      step("R8", we, ws, wd, rs);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule